// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system issue single reads and writes to an external asynchronous static RAM that has 20 address lines and a 4-bit data bus. A request carries an address, write data and a direction flag, and is taken through a valid/ready handshake. The controller then drives the memory's active-low chip-select, output-strobe and write-strobe pins. It controls the shared data bus through separate drive-value, drive-enable and sampled-input signals. A finished read returns its data with a one-cycle done pulse.

Every analog timing limit of the memory is a parameter in nanoseconds. Each one is turned into a whole number of clock cycles by rounding up, with a floor of one cycle. After reset the controller waits out a power-up interval before it accepts any request. It holds the output strobe high for the whole of a write. After a read it leaves the bus idle long enough for the memory's outputs to float before it can drive write data. Between accesses chip select stays high, so the memory can drop into its low-power state.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0, `req_ready` is 0 and `rsp_done` is 0.
- R2: After reset is released, `req_ready` stays 0 for exactly ceil(T_PWRUP_NS/CLK_NS) clock edges (250 with the defaults). During that wait `sram_ce_n` stays 1 even when `req_valid` is held high.
- R3: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the access, including any turnaround, is complete. Every offered request is taken exactly once.
- R4: A read (`req_write`=0) holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 with a stable address for max(ceil(tAA), ceil(tRC)) cycles (3 with the defaults). The pins change on the clock edge that takes the request.
- R5: `rsp_rdata` is the value of `sram_dq_in` sampled on the last cycle of the read window. `rsp_done` is 1 for exactly one cycle, starting on the edge that ends the window, and `rsp_rdata` is valid at that time.
- R6: A write (`req_write`=1) holds `sram_ce_n`=0 and `sram_we_n`=0, with `sram_dq_oe`=1 driving `req_wdata`, for the largest of ceil(strobe width), ceil(address-to-end), ceil(data setup) and ceil(write cycle) minus one cycles (2 with the defaults). One further cycle follows with `sram_we_n`=1 and the data still driven. `sram_oe_n` is 1 throughout.
- R7: After a read window ends, `sram_dq_oe` stays 0 for at least ceil(tHZOE) cycles after `sram_oe_n` rises (2 with the defaults). No new request is taken before those cycles have passed.
- R8: While no access is in progress, `sram_ce_n` is 1.
- R9: `sram_dq_oe` is never 1 while `sram_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data to write |
| rsp_done | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | DATA_W | Captured read data |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_out | output | DATA_W | Value to drive on the data bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | DATA_W | Value sampled from the data bus |

## Verification
Two events can fall on the same cycle here. The first is the end of the power-up wait meeting a request that has been held valid since reset. The bench holds a read request asserted through the whole wait and checks that it is taken on the first edge where ready is high and not one edge earlier. The second is the end of a read (done pulse, output strobe rising) meeting a write that is queued directly behind it. The bench offers the write on the cycle after the read is taken. A memory model then reports any bus drive that begins within the float interval, as well as the exact number of cycles until ready returns.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM access controller.
// Assumes all timing figures are given in whole nanoseconds.
package sram_ctrl_pkg;

    // Sequencer states; the pin register decodes the next state of these.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_WEND
    } seq_state_t;

    // Rounds a nanosecond interval up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Larger of two integers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwr_wait.sv
// Power-up gate: raises pwr_ok once PWR_CYC clock edges have passed after
// reset release. Assumes PWR_CYC >= 1. Holds pwr_ok high until next reset.
module sram_pwr_wait #(
    parameter int PWR_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwr_ok
);
    localparam int CW = $clog2(PWR_CYC + 1);

    logic [CW-1:0] cnt;

    // Counts edges since reset release and latches completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            pwr_ok <= 1'b0;
        end else if (!pwr_ok) begin
            if (cnt == CW'(PWR_CYC - 1)) pwr_ok <= 1'b1;
            else                          cnt    <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/sram_seq.sv
// Access sequencer: takes one request at a time, times the read window, the
// post-read float interval, the write strobe and the write-end cycle, and
// captures read data. Assumes every cycle count parameter is >= 1.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int RD_CYC = 3,
    parameter int WR_LOW = 2,
    parameter int HZ_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] dq_in,
    output logic              req_ready,
    output logic              accept,
    output seq_state_t        nxt_state,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int CNT_MAX = max2(RD_CYC, max2(WR_LOW, HZ_CYC));
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          read_last;

    // Handshake: ready only when idle and the power-up wait is over.
    always_comb begin
        req_ready = (state == ST_IDLE) && pwr_ok;
        accept    = req_valid && req_ready;
        read_last = (state == ST_READ) && (cnt == CW'(RD_CYC - 1));
    end

    // Next state and interval counter.
    always_comb begin
        nxt_state = state;
        cnt_nxt   = cnt;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    nxt_state = req_write ? ST_WRITE : ST_READ;
                    cnt_nxt   = '0;
                end
            end
            ST_READ: begin
                if (cnt == CW'(RD_CYC - 1)) begin
                    nxt_state = ST_TURN;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            ST_TURN: begin
                if (cnt == CW'(HZ_CYC - 1)) begin
                    nxt_state = ST_IDLE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            ST_WRITE: begin
                if (cnt == CW'(WR_LOW - 1)) begin
                    nxt_state = ST_WEND;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            ST_WEND:  nxt_state = ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= cnt_nxt;
        end
    end

    // Read capture on the last window cycle, with a one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= read_last;
            if (read_last) rsp_rdata <= dq_in;
        end
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R5

endmodule

// File: rtl/sram_pin_reg.sv
// Pin register: every memory control pin and the bus drive come straight
// from a flop, loaded from the sequencer's next state, so the pins carry no
// decode glitches. Address and write data are latched when a request is taken.
module sram_pin_reg
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        nxt_state,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe
);
    logic ce_d, oe_d, we_d, drv_d;

    // Decodes the next state into active-high pin intents.
    always_comb begin
        ce_d  = (nxt_state == ST_READ) || (nxt_state == ST_WRITE) || (nxt_state == ST_WEND);
        oe_d  = (nxt_state == ST_READ);
        we_d  = (nxt_state == ST_WRITE);
        drv_d = (nxt_state == ST_WRITE) || (nxt_state == ST_WEND);
    end

    // Control pins and bus drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_ce_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            sram_ce_n  <= !ce_d;
            sram_oe_n  <= !oe_d;
            sram_we_n  <= !we_d;
            sram_dq_oe <= drv_d;
        end
    end

    // Address and write data, held from acceptance until the next request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
        end else if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_wdata;
        end
    end

    AST_DRIVE_NEEDS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n); // R9
    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe)); // R6
    AST_TURNAROUND_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> !sram_dq_oe); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R4

endmodule

// File: rtl/sram_access_ctrl.sv
// Top of the asynchronous SRAM access controller. Converts nanosecond
// timing parameters to cycle counts and wires the power-up gate, the
// sequencer and the pin register. Assumes the data bus tri-state buffer
// lives outside, controlled by sram_dq_oe.
module sram_access_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 4,
    parameter int CLK_NS      = 4,
    parameter int T_AA_NS     = 12,
    parameter int T_RC_NS     = 12,
    parameter int T_WC_NS     = 12,
    parameter int T_PWE_NS    = 8,
    parameter int T_AW_NS     = 8,
    parameter int T_SD_NS     = 6,
    parameter int T_HZOE_NS   = 6,
    parameter int T_PWRUP_NS  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int RD_CYC  = max2(ns_to_cycles(T_AA_NS, CLK_NS), ns_to_cycles(T_RC_NS, CLK_NS));
    localparam int WR_LOW  = max2(max2(ns_to_cycles(T_PWE_NS, CLK_NS), ns_to_cycles(T_AW_NS, CLK_NS)),
                                  max2(ns_to_cycles(T_SD_NS, CLK_NS), ns_to_cycles(T_WC_NS, CLK_NS) - 1));
    localparam int HZ_CYC  = ns_to_cycles(T_HZOE_NS, CLK_NS);
    localparam int PWR_CYC = ns_to_cycles(T_PWRUP_NS, CLK_NS);

    logic       pwr_ok;
    logic       accept;
    seq_state_t nxt_state;

    sram_pwr_wait #(.PWR_CYC(PWR_CYC)) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok)
    );

    sram_seq #(
        .DATA_W (DATA_W),
        .RD_CYC (RD_CYC),
        .WR_LOW (WR_LOW),
        .HZ_CYC (HZ_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .req_valid (req_valid),
        .req_write (req_write),
        .dq_in     (sram_dq_in),
        .req_ready (req_ready),
        .accept    (accept),
        .nxt_state (nxt_state),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata)
    );

    sram_pin_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .nxt_state   (nxt_state),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .sram_addr   (sram_addr),
        .sram_ce_n   (sram_ce_n),
        .sram_oe_n   (sram_oe_n),
        .sram_we_n   (sram_we_n),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe)
    );

    AST_POWERUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> sram_ce_n); // R2
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> sram_ce_n); // R8

endmodule

// File: tb/test_sram_access_ctrl.sv
`timescale 1ns/1ps
module test_sram_access_ctrl;
    localparam int CLK_NS = 4;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD_CYC  = 3;   // ceil(12/4)
    localparam int WR_LOW  = 2;   // ceil(8/4)
    localparam int HZ_CYC  = 2;   // ceil(6/4)
    localparam int PWR_CYC = 250; // ceil(1000/4)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [3:0]  rsp_rdata;
    logic [19:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [3:0]  sram_dq_out;
    logic [3:0]  sram_dq_in = '0;

    always #2 clk = ~clk;

    sram_access_ctrl i_sram_access_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    int vectors = 0;
    int fails = 0;
    int issued = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model, one update per cycle at the negedge ----
    logic [3:0] mem [int];
    int rd_age = 0, rd_len_last = 0, wlow = 0, wlow_last = 0;
    int hold_err = 0, contention_err = 0, turn_err = 0, accepts = 0;
    int oe_since = 1000;
    logic [19:0] last_addr = '0;
    logic [3:0]  wdat = '0;

    function automatic logic [3:0] memv(input logic [19:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[3:0] ^ 4'h5;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            rd_age = 0; wlow = 0; oe_since = 1000; sram_dq_in = '0;
        end else begin
            if (req_valid && req_ready) accepts++;
            if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
                if (rd_age > 0 && sram_addr == last_addr) rd_age++;
                else rd_age = 1;
                sram_dq_in = (rd_age >= RD_CYC) ? memv(sram_addr) : ~memv(sram_addr);
            end else begin
                if (rd_age > 0) rd_len_last = rd_age;
                rd_age = 0;
                sram_dq_in = '0;
            end
            last_addr = sram_addr;
            if (!sram_ce_n && !sram_we_n) begin
                wlow++;
                wdat = sram_dq_out;
                if (!sram_dq_oe) hold_err++;
            end else if (wlow > 0) begin
                wlow_last = wlow;
                if (!sram_dq_oe || sram_dq_out != wdat || sram_ce_n) hold_err++;
                mem[int'(sram_addr)] = wdat;
                wlow = 0;
            end
            if (sram_dq_oe && !sram_ce_n && !sram_oe_n) contention_err++;
            if (!sram_oe_n) oe_since = 0;
            else if (oe_since < 1000) oe_since++;
            if (sram_dq_oe && oe_since <= HZ_CYC) turn_err++;
        end
    end

    // ---------------- scenarios ---------------------------------------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sram_ce_n && sram_oe_n && sram_we_n, "R1", "strobes idle in reset",
              {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        check(!sram_dq_oe, "R1", "no drive in reset", sram_dq_oe, 0);
        check(!req_ready && !rsp_done, "R1", "ready/done low in reset",
              {req_ready, rsp_done}, 0);
    endtask

    // Request held valid across the whole power-up wait.
    task automatic t_powerup();
        bit quiet = 1'b1;
        int n = 0;
        rst_n = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00ABC;
        issued++;
        for (int k = 1; k <= PWR_CYC; k++) begin
            @(negedge clk);
            if (!sram_ce_n) quiet = 1'b0;
            if (k == PWR_CYC - 1) check(!req_ready, "R2", "ready one edge early", req_ready, 0);
            if (k == PWR_CYC)     check(req_ready,  "R2", "ready at end of wait", req_ready, 1);
        end
        check(quiet, "R2", "chip select quiet during wait", quiet, 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done && n < 20) begin @(negedge clk); n++; end
        check(rsp_rdata == memv(20'h00ABC), "R5", "first read after wait",
              rsp_rdata, memv(20'h00ABC));
    endtask

    task automatic do_write(input logic [19:0] a, input logic [3:0] d);
        int n = 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        issued++;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R3", "ready low after write taken", req_ready, 0);
        while (!req_ready && n < 20) begin @(negedge clk); n++; end
        check(n == WR_LOW + 2, "R3", "write occupancy cycles", n, WR_LOW + 2);
        check(wlow_last == WR_LOW, "R6", "write strobe cycles", wlow_last, WR_LOW);
    endtask

    task automatic do_read(input logic [19:0] a, input logic [3:0] exp);
        int n = 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        issued++;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!sram_ce_n && !sram_oe_n && sram_we_n, "R4", "read strobes after accept",
              {sram_ce_n, sram_oe_n, sram_we_n}, 3'b001);
        while (!rsp_done && n < 20) begin @(negedge clk); n++; end
        check(n == RD_CYC + 1, "R5", "done latency", n, RD_CYC + 1);
        check(rsp_rdata == exp, "R5", "read data", rsp_rdata, exp);
        @(negedge clk); n++;
        check(!rsp_done, "R5", "done is one cycle", rsp_done, 0);
        while (!req_ready && n < 20) begin @(negedge clk); n++; end
        check(n == RD_CYC + HZ_CYC + 1, "R7", "read plus float cycles", n, RD_CYC + HZ_CYC + 1);
        check(rd_len_last == RD_CYC, "R4", "read window cycles", rd_len_last, RD_CYC);
    endtask

    // Write queued right behind a read: float interval must be honoured.
    task automatic t_read_then_write();
        int n = 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h12345;
        issued++;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_write = 1'b1; req_addr = 20'h12346; req_wdata = 4'h9;
        issued++;
        while (!req_ready && n < 20) begin @(negedge clk); n++; end
        check(n == RD_CYC + HZ_CYC + 1, "R7", "queued write waits float", n, RD_CYC + HZ_CYC + 1);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(turn_err == 0, "R7", "drive inside float interval", turn_err, 0);
        do_read(20'h12346, 4'h9);
    endtask

    task automatic t_idle();
        bit quiet = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (!sram_ce_n || !sram_oe_n || !sram_we_n) quiet = 1'b0;
        end
        check(quiet, "R8", "deselected while idle", quiet, 1);
    endtask

    initial begin
        t_reset();
        t_powerup();
        do_write(20'h00000, 4'hF);
        do_write(20'hFFFFF, 4'h0);
        do_write(20'h5A5A5, 4'h6);
        do_read(20'h00000, 4'hF);
        do_read(20'hFFFFF, 4'h0);
        do_read(20'h5A5A5, 4'h6);
        do_read(20'h00777, memv(20'h00777));
        t_read_then_write();
        t_idle();
        check(contention_err == 0, "R9", "drive while memory outputs", contention_err, 0);
        check(hold_err == 0, "R6", "write data held through strobe end", hold_err, 0);
        check(accepts == issued, "R3", "requests taken once", accepts, issued);
        check(cyc(1000) == PWR_CYC, "R2", "power-up count derivation", cyc(1000), PWR_CYC);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule